// File: doc/BRIEF.md
# Down-Converter Output Sample Formatter

This block sits at the end of a two-channel digital down-converter. It receives one complex baseband sample per channel (in-phase and quadrature, 32-bit two's complement each) together with a single valid strobe. It converts all four words to one selectable output format: two's complement at 8, 16, 24 or 32 bits, or a 12-bit floating point word made of a 4-bit exponent and an 8-bit mantissa. The converted set is held in output registers and delivered in two ways at once: a 16-bit parallel port read by a word-select input, and a bit-serial port with its own clock, frame sync and one or two data lanes.

The format code and the lane mode are captured together with the samples. The parallel port has an enable that gates its data and its read strobe. A ready flag marks a fresh output set. It clears either when the last parallel slice of the set is read or when the serial frame finishes. The serial clock, the frame sync and the ready flag each have a polarity input.

Top module: `ddc_out_fmt`

## Requirements
- R1: Format code 0 gives 8-bit words equal to bits 31..24 of the input, with no rounding.
- R2: Format codes 1 and 2 give 16-bit and 24-bit words, rounded half-up by adding the first dropped bit to the kept upper bits; a sum that would pass the largest positive code saturates to it (16'h7FFF or 24'h7FFFFF).
- R3: Format code 3 (and the unused codes 5 to 7) passes the 32-bit word unchanged.
- R4: Format code 4 gives a 12-bit word {exponent[11:8], mantissa[7:0]}: the input is shifted left while its top two bits are equal, at most 15 times; the exponent is 15 minus the shift count and the mantissa is bits 31..24 after the shift.
- R5: For word lengths of 16 bits or fewer, pout shows the word chosen by psel[1:0] (0 = A in-phase, 1 = A quadrature, 2 = B in-phase, 3 = B quadrature), right-justified: 8-bit words sign-extended, 12-bit float words zero-extended; psel[2] is ignored.
- R6: For 24-bit and 32-bit words, psel[2:1] chooses the word in the same order and psel[0] chooses the half of the word left-justified into 32 bits (0 = bits 31..16, 1 = bits 15..0).
- R7: With pout_en low, pout is all zeros and prd has no effect on the ready flag.
- R8: Each serial word is sent as one sync slot (frame sync active, data low) followed by the word MSB first, one bit per serial clock period of 2*SCK_HALF clocks; the serial clock idles inactive and runs only during a frame.
- R9: With mux_one high all four words go out on sout_a in the order A in-phase, A quadrature, B in-phase, B quadrature and sout_b stays low; with it low, sout_a carries the A pair and sout_b carries the B pair in step.
- R10: sck, sfs and rdy are the internal levels XOR sck_inv, sfs_inv and rdy_inv respectively.
- R11: The ready flag becomes active on the clock edge that takes in_valid, and goes inactive after prd with pout_en high reads the last slice (psel[1:0] = 3 for narrow words, psel = 7 for wide words).
- R12: The ready flag goes inactive when the serial frame ends, if it is still active.
- R13: fmt_sel and mux_one are captured with the samples; changing them afterwards does not alter the held set on either port.
- R14: After reset the ready flag, serial clock, frame sync, data lanes and pout are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Latch a new sample set |
| a_i | input | 32 | Channel A in-phase sample |
| a_q | input | 32 | Channel A quadrature sample |
| b_i | input | 32 | Channel B in-phase sample |
| b_q | input | 32 | Channel B quadrature sample |
| fmt_sel | input | 3 | Output format code |
| mux_one | input | 1 | 1: all words on sout_a; 0: one lane per channel |
| sck_inv | input | 1 | Invert serial clock |
| sfs_inv | input | 1 | Invert frame sync |
| rdy_inv | input | 1 | Invert ready flag |
| pout_en | input | 1 | Parallel port enable |
| psel | input | 3 | Parallel slice select |
| prd | input | 1 | Parallel read strobe |
| pout | output | 16 | Parallel data |
| sck | output | 1 | Serial clock |
| sfs | output | 1 | Serial frame sync |
| sout_a | output | 1 | Serial data lane A |
| sout_b | output | 1 | Serial data lane B |
| rdy | output | 1 | Ready flag |

## Verification
The hardest situations are the rounding edges: the saturating case only appears when the kept bits already hold the largest positive code and the first dropped bit is set, and the float path only reaches its clamp when the input has more than fifteen redundant sign bits. The stimulus drives hand-picked words such as 32'h7FFF_8000, 32'h7FFF_FF80, all-ones and zero through each format, with the serial frame and the parallel reads of the same set both compared against a scoreboard. The race between the two ways of clearing the ready flag is reached by reading the last parallel slice while the serial frame is still running, and by attempting the read with the port disabled.

// File: rtl/ddc_fmt_pkg.sv
package ddc_fmt_pkg;
  localparam int DW    = 32;
  localparam int PW    = 16;
  localparam int NWORD = 4;

  localparam logic [2:0] FMT_T8  = 3'd0;
  localparam logic [2:0] FMT_R16 = 3'd1;
  localparam logic [2:0] FMT_R24 = 3'd2;
  localparam logic [2:0] FMT_T32 = 3'd3;
  localparam logic [2:0] FMT_FLT = 3'd4;

  // number of bits carried per word for a format code
  function automatic logic [5:0] fmt_width(input logic [2:0] f);
    case (f)
      FMT_T8:  return 6'd8;
      FMT_R16: return 6'd16;
      FMT_R24: return 6'd24;
      FMT_FLT: return 6'd12;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic fmt_is_wide(input logic [2:0] f);
    return fmt_width(f) > 6'(PW);
  endfunction

  // keep the top n bits, round half-up, saturate at the largest positive code
  function automatic logic [DW-1:0] round_keep(input logic [DW-1:0] x, input int n);
    logic signed [DW-1:0] top;
    logic [DW-1:0] mask;
    logic [DW-1:0] maxp;
    logic          half;
    top  = $signed(x) >>> (DW - n);
    mask = (DW'(1) << n) - DW'(1);
    maxp = (DW'(1) << (n - 1)) - DW'(1);
    half = x[DW-1-n];
    if (half && (top == $signed(maxp))) return maxp;
    return (DW'(top) + DW'(half)) & mask;
  endfunction

  // normalise by left shifts until the top two bits differ, at most 15 shifts
  function automatic logic [11:0] to_float(input logic [DW-1:0] x);
    logic [DW-1:0] s;
    logic [3:0]    sh;
    s  = x;
    sh = 4'd0;
    for (int i = 0; i < 15; i++) begin
      if (s[DW-1] == s[DW-2]) begin
        s  = s << 1;
        sh = sh + 4'd1;
      end
    end
    return {4'hF - sh, s[DW-1:DW-8]};
  endfunction

  function automatic logic [DW-1:0] fmt_convert(input logic [DW-1:0] x, input logic [2:0] f);
    case (f)
      FMT_T8:  return {24'd0, x[DW-1:DW-8]};
      FMT_R16: return round_keep(x, 16);
      FMT_R24: return round_keep(x, 24);
      FMT_FLT: return {20'd0, to_float(x)};
      default: return x;
    endcase
  endfunction

  // 16-bit view of a held word for the parallel port
  function automatic logic [PW-1:0] par_slice(input logic [DW-1:0] w, input logic [2:0] f,
                                              input logic lower);
    case (f)
      FMT_T8:  return {{8{w[7]}}, w[7:0]};
      FMT_R16: return w[15:0];
      FMT_FLT: return {4'd0, w[11:0]};
      FMT_R24: return lower ? {w[7:0], 8'd0} : w[23:8];
      default: return lower ? w[15:0] : w[31:16];
    endcase
  endfunction
endpackage

// File: rtl/ddc_fmt_conv.sv
module ddc_fmt_conv
  import ddc_fmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] x,
  input  logic [2:0]    fmt,
  output logic [DW-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= fmt_convert(x, fmt);
  end
endmodule

// File: rtl/ddc_fmt_par.sv
module ddc_fmt_par
  import ddc_fmt_pkg::*;
(
  input  logic [NWORD-1:0][DW-1:0] words,
  input  logic [2:0]               fmt,
  input  logic [2:0]               psel,
  input  logic                     pout_en,
  input  logic                     prd,
  output logic [PW-1:0]            pout,
  output logic                     last_rd
);
  logic       wide;
  logic [1:0] widx;
  logic       is_last;

  always_comb begin
    wide    = fmt_is_wide(fmt);
    widx    = wide ? psel[2:1] : psel[1:0];
    is_last = wide ? (psel == 3'd7) : (psel[1:0] == 2'd3);
    pout    = pout_en ? par_slice(words[widx], fmt, psel[0]) : '0;
    last_rd = prd & pout_en & is_last;
  end
endmodule

// File: rtl/ddc_fmt_ser.sv
module ddc_fmt_ser
  import ddc_fmt_pkg::*;
#(
  parameter int SCK_HALF = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               fmt,
  input  logic                     mux,
  input  logic [NWORD-1:0][DW-1:0] words,
  output logic                     sck_raw,
  output logic                     sfs_raw,
  output logic                     sout_a,
  output logic                     sout_b,
  output logic                     active,
  output logic                     frame_done
);
  localparam int PER  = 2 * SCK_HALF;
  localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;

  logic [PH_W-1:0] ph;
  logic [5:0]      slot;
  logic [1:0]      widx;
  logic [5:0]      wlen;
  logic            last_ph, last_slot, last_word;
  logic [4:0]      bidx;
  logic            data_slot;

  always_comb begin
    wlen       = fmt_width(fmt);
    last_ph    = (ph == PH_W'(PER - 1));
    last_slot  = (slot == wlen);
    last_word  = mux ? (widx == 2'd3) : (widx == 2'd1);
    frame_done = active & last_ph & last_slot & last_word;
    bidx       = 5'(wlen - slot);
    data_slot  = active & (slot != 6'd0);
    sck_raw    = active & (ph >= PH_W'(SCK_HALF));
    sfs_raw    = active & (slot == 6'd0);
    sout_a     = data_slot & words[widx][bidx];
    sout_b     = data_slot & ~mux & words[{1'b1, widx[0]}][bidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      slot   <= '0;
      widx   <= '0;
    end else if (start) begin
      active <= 1'b1;
      ph     <= '0;
      slot   <= '0;
      widx   <= '0;
    end else if (active) begin
      if (last_ph) begin
        ph <= '0;
        if (last_slot) begin
          slot <= '0;
          if (last_word) active <= 1'b0;
          else           widx   <= widx + 2'd1;
        end else begin
          slot <= slot + 6'd1;
        end
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddc_out_fmt.sv
module ddc_out_fmt
  import ddc_fmt_pkg::*;
#(
  parameter int SCK_HALF = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] a_q,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] b_q,
  input  logic [2:0]    fmt_sel,
  input  logic          mux_one,
  input  logic          sck_inv,
  input  logic          sfs_inv,
  input  logic          rdy_inv,
  input  logic          pout_en,
  input  logic [2:0]    psel,
  input  logic          prd,
  output logic [PW-1:0] pout,
  output logic          sck,
  output logic          sfs,
  output logic          sout_a,
  output logic          sout_b,
  output logic          rdy
);
  logic [NWORD-1:0][DW-1:0] raw_w;
  logic [NWORD-1:0][DW-1:0] held_w;
  logic [2:0] fmt_q;
  logic       mux_q;
  logic       rdy_raw;

  // named events for the checker
  logic latch_evt;
  logic frame_done;
  logic par_last_rd;
  logic ser_active;
  logic sck_raw, sfs_raw;

  assign raw_w     = {b_q, b_i, a_q, a_i};
  assign latch_evt = in_valid;

  for (genvar g = 0; g < NWORD; g++) begin : g_conv
    ddc_fmt_conv conv_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (latch_evt),
      .x      (raw_w[g]),
      .fmt    (fmt_sel),
      .word_q (held_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_T8;
      mux_q <= 1'b0;
    end else if (latch_evt) begin
      fmt_q <= fmt_sel;
      mux_q <= mux_one;
    end
  end

  ddc_fmt_par par_i (
    .words   (held_w),
    .fmt     (fmt_q),
    .psel    (psel),
    .pout_en (pout_en),
    .prd     (prd),
    .pout    (pout),
    .last_rd (par_last_rd)
  );

  ddc_fmt_ser #(.SCK_HALF(SCK_HALF)) ser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (latch_evt),
    .fmt        (fmt_q),
    .mux        (mux_q),
    .words      (held_w),
    .sck_raw    (sck_raw),
    .sfs_raw    (sfs_raw),
    .sout_a     (sout_a),
    .sout_b     (sout_b),
    .active     (ser_active),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rdy_raw <= 1'b0;
    else if (latch_evt)                 rdy_raw <= 1'b1;
    else if (par_last_rd || frame_done) rdy_raw <= 1'b0;
  end

  assign sck = sck_raw ^ sck_inv;
  assign sfs = sfs_raw ^ sfs_inv;
  assign rdy = rdy_raw ^ rdy_inv;
endmodule

// File: rtl/ddc_out_fmt_chk.sv
module ddc_out_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        rdy,
  input logic        rdy_inv,
  input logic        sck,
  input logic        sck_inv,
  input logic        sfs,
  input logic        sfs_inv,
  input logic        sout_a,
  input logic        sout_b,
  input logic        pout_en,
  input logic [15:0] pout,
  input logic        frame_done,
  input logic        par_last_rd,
  input logic        ser_active
);
  AST_RDY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (rdy != rdy_inv)); // R11
  AST_RDY_CLR_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (par_last_rd && !in_valid) |=> (rdy == rdy_inv)); // R11
  AST_RDY_CLR_SER: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !in_valid) |=> (rdy == rdy_inv)); // R12
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_active |-> (sck == sck_inv)); // R10
  AST_SFS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (sfs != sfs_inv) |-> ser_active); // R8
  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_active |-> (!sout_a && !sout_b)); // R8
  AST_POUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pout_en |-> (pout == 16'd0)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R12
endmodule

bind ddc_out_fmt ddc_out_fmt_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rdy         (rdy),
  .rdy_inv     (rdy_inv),
  .sck         (sck),
  .sck_inv     (sck_inv),
  .sfs         (sfs),
  .sfs_inv     (sfs_inv),
  .sout_a      (sout_a),
  .sout_b      (sout_b),
  .pout_en     (pout_en),
  .pout        (pout),
  .frame_done  (frame_done),
  .par_last_rd (par_last_rd),
  .ser_active  (ser_active)
);

// File: tb/ddc_out_fmt_tb_top.sv
`timescale 1ns/1ps
module ddc_out_fmt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
  logic [2:0] fmt_sel = 3'd0;
  logic mux_one = 1'b0, sck_inv = 1'b0, sfs_inv = 1'b0, rdy_inv = 1'b0;
  logic pout_en = 1'b1, prd = 1'b0;
  logic [2:0] psel = 3'd0;
  logic [15:0] pout;
  logic sck, sfs, sout_a, sout_b, rdy;

  always #2.5 clk = ~clk;

  ddc_out_fmt dut_i (.*);

  int n_chk = 0;
  int n_err = 0;
  logic [39:0] qa[$];
  logic [39:0] qb[$];
  logic [31:0] cur_w[4];
  int          cur_len;
  int          cur_fmt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int f);
    if (f == 0) return 8;
    if (f == 1) return 16;
    if (f == 2) return 24;
    if (f == 4) return 12;
    return 32;
  endfunction

  function automatic logic [31:0] exp_val(input logic [31:0] x, input int f);
    longint sx, t, mx;
    int n, lead, sh;
    logic [31:0] y;
    if (f == 0) return {24'd0, x[31:24]};
    if (f == 1 || f == 2) begin
      n  = (f == 1) ? 16 : 24;
      sx = longint'($signed(x));
      t  = (sx + (longint'(1) << (31 - n))) >>> (32 - n);
      mx = (longint'(1) << (n - 1)) - 1;
      if (t > mx) t = mx;
      return 32'(t & ((longint'(1) << n) - 1));
    end
    if (f == 4) begin
      lead = 0;
      for (int i = 30; i >= 0; i--) begin
        if (x[i] == x[31]) lead++;
        else break;
      end
      sh = (lead > 15) ? 15 : lead;
      y  = x << sh;
      return {20'd0, 4'(15 - sh), y[31:24]};
    end
    return x;
  endfunction

  function automatic logic [15:0] exp_par(input logic [31:0] v, input int len, input bit lower);
    logic [31:0] j;
    if (len == 8)  return {{8{v[7]}}, v[7:0]};
    if (len == 12) return {4'd0, v[11:0]};
    if (len == 16) return v[15:0];
    j = v << (32 - len);
    return lower ? j[15:0] : j[31:16];
  endfunction

  // driver: applies a set and pushes the expected serial words
  task automatic send_set(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    logic [31:0] v[4];
    @(negedge clk);
    a_i = w0; a_q = w1; b_i = w2; b_q = w3;
    in_valid = 1'b1;
    cur_fmt = int'(fmt_sel);
    cur_len = exp_len(cur_fmt);
    v[0] = w0; v[1] = w1; v[2] = w2; v[3] = w3;
    for (int k = 0; k < 4; k++) cur_w[k] = exp_val(v[k], cur_fmt);
    if (mux_one) begin
      for (int k = 0; k < 4; k++) qa.push_back({8'(cur_len), cur_w[k]});
    end else begin
      qa.push_back({8'(cur_len), cur_w[0]});
      qa.push_back({8'(cur_len), cur_w[1]});
      qb.push_back({8'(cur_len), cur_w[2]});
      qb.push_back({8'(cur_len), cur_w[3]});
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_par(input string tag);
    logic [15:0] e;
    int nsel;
    nsel = (cur_len > 16) ? 8 : 4;
    for (int s = 0; s < nsel; s++) begin
      psel = 3'(s);
      #1;
      if (cur_len > 16) e = exp_par(cur_w[s/2], cur_len, s[0]);
      else              e = exp_par(cur_w[s], cur_len, 1'b0);
      chk(pout == e, tag, 64'(pout), 64'(e));
    end
    if (cur_len <= 16) begin
      psel = 3'd6;
      #1;
      e = exp_par(cur_w[2], cur_len, 1'b0);
      chk(pout == e, {tag, " R5 psel2 ignored"}, 64'(pout), 64'(e));
    end
  endtask

  task automatic read_slice(input int s);
    @(negedge clk);
    psel = 3'(s);
    prd  = 1'b1;
    @(negedge clk);
    prd  = 1'b0;
  endtask

  // monitor: serial receiver comparing against the scoreboard
  logic prev_sck = 1'b0;
  logic coll = 1'b0;
  int   bcnt = 0;
  logic [31:0] sra, srb;
  always @(negedge clk) begin
    logic sck_r, sfs_r;
    logic [39:0] it;
    sck_r = sck ^ sck_inv;
    sfs_r = sfs ^ sfs_inv;
    if (!rst_n) begin
      coll = 1'b0;
      sck_r = 1'b0;
    end else if (sck_r && !prev_sck) begin
      if (sfs_r) begin
        coll = 1'b1; bcnt = 0; sra = '0; srb = '0;
      end else if (coll) begin
        sra = {sra[30:0], sout_a};
        srb = {srb[30:0], sout_b};
        bcnt++;
        if (qa.size() == 0) begin
          chk(1'b0, "R8 unexpected serial word", 64'(sra), 64'd0);
          coll = 1'b0;
        end else if (bcnt == int'(qa[0][39:32])) begin
          it = qa.pop_front();
          chk(sra == it[31:0], "R8/R9 serial lane A word", 64'(sra), 64'(it[31:0]));
          if (qb.size() != 0) begin
            it = qb.pop_front();
            chk(srb == it[31:0], "R9 serial lane B word", 64'(srb), 64'(it[31:0]));
          end else begin
            chk(srb == 32'd0, "R9 lane B quiet in muxed mode", 64'(srb), 64'd0);
          end
          coll = 1'b0;
        end
      end
    end
    prev_sck = sck_r;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk(rdy == 1'b0 && sck == 1'b0 && sfs == 1'b0, "R14 reset strobes", {rdy, sck, sfs}, 0);
    chk(sout_a == 1'b0 && sout_b == 1'b0 && pout == 16'd0, "R14 reset data", {sout_a, sout_b, pout}, 0);

    // R1 8-bit truncation, separate lanes, serial end clears ready (R12)
    fmt_sel = 3'd0; mux_one = 1'b0;
    send_set(32'h7F12_3456, 32'h80FF_FFFF, 32'h00FF_0000, 32'hFE00_0001);
    chk(rdy == 1'b1, "R11 ready on latch", 64'(rdy), 1);
    check_par("R1 R5 8-bit parallel");
    repeat (300) @(negedge clk);
    chk(rdy == 1'b0, "R12 ready cleared by serial end", 64'(rdy), 0);

    // R2 16-bit rounding corners, muxed lane
    fmt_sel = 3'd1; mux_one = 1'b1;
    send_set(32'h7FFF_8000, 32'h1234_8000, 32'hFFFF_7FFF, 32'h8000_0000);
    check_par("R2 R5 16-bit round/saturate");
    repeat (300) @(negedge clk);

    // R2 24-bit rounding, wide parallel, read-out clears ready (R11)
    fmt_sel = 3'd2; mux_one = 1'b0;
    send_set(32'h7FFF_FF80, 32'h0000_0080, 32'hFFFF_FF7F, 32'h8000_007F);
    check_par("R2 R6 24-bit parallel");
    for (int s = 0; s < 7; s++) read_slice(s);
    chk(rdy == 1'b1, "R11 ready held before last slice", 64'(rdy), 1);
    read_slice(7);
    chk(rdy == 1'b0, "R11 ready cleared by last slice", 64'(rdy), 0);
    repeat (300) @(negedge clk);

    // R3 32-bit passthrough with inverted strobes (R10)
    @(negedge clk);
    fmt_sel = 3'd3; mux_one = 1'b1;
    sck_inv = 1'b1; sfs_inv = 1'b1; rdy_inv = 1'b1;
    #1;
    chk(sck == 1'b1 && sfs == 1'b1 && rdy == 1'b1, "R10 inverted idle levels", {sck, sfs, rdy}, 3'b111);
    send_set(32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0001, 32'h7FFF_FFFE);
    chk(rdy == 1'b0, "R10 active-low ready", 64'(rdy), 0);
    check_par("R3 R6 32-bit parallel");
    repeat (300) @(negedge clk);
    chk(rdy == 1'b1, "R10 R12 ready inactive high", 64'(rdy), 1);
    sck_inv = 1'b0; sfs_inv = 1'b0; rdy_inv = 1'b0;

    // R4 float, then capture (R13) and output enable (R7)
    fmt_sel = 3'd4; mux_one = 1'b0;
    send_set(32'h0012_3456, 32'h4000_0000, 32'hFFFF_FFFF, 32'h0000_0000);
    fmt_sel = 3'd0; mux_one = 1'b1;
    check_par("R4 R13 float held after format change");
    @(negedge clk);
    pout_en = 1'b0;
    psel = 3'd1;
    #1;
    chk(pout == 16'd0, "R7 pout gated", 64'(pout), 0);
    read_slice(3);
    chk(rdy == 1'b1, "R7 read ignored while disabled", 64'(rdy), 1);
    pout_en = 1'b1;
    repeat (300) @(negedge clk);
    chk(rdy == 1'b0, "R12 ready cleared after float frame", 64'(rdy), 0);

    // unused format code behaves as 32-bit (R3)
    fmt_sel = 3'd6; mux_one = 1'b0;
    send_set(32'h1357_9BDF, 32'h2468_ACE0, 32'hFFFF_0000, 32'h0000_FFFF);
    check_par("R3 unused code as 32-bit");
    repeat (300) @(negedge clk);

    chk(qa.size() == 0 && qb.size() == 0, "R8 scoreboard drained", 64'(qa.size() + qb.size()), 0);
    finish_run();
  end
endmodule